// File: doc/BRIEF.md
# Strap-Configured Clock Enable Generator

This block reads a 16-bit bundle of board configuration pins while its synchronous reset is held. When reset drops, it freezes the captured value. From that frozen value it derives three clock-enable streams from one fast core clock: a system enable, a memory enable and an external-device enable. Each stream runs at a ratio picked by its own strap field. The memory stream can run at a fractional ratio of 1.5.

The same frozen value also drives several static controls. These are a PLL enable and its complementary bypass flag, a 3-bit core frequency code for the PLL, the direction of the serial-interface bit clock, the source of the timer and baud oscillator, and four board-identification bits that firmware reads to learn which board it is running on.

All outputs are registered and synchronous to `clk`. The enables are one-cycle pulses that gate logic in the core clock domain. They are not separate clocks.

Top module: `strap_clk_unit`

## Requirements
- R1: While `rst` is high, the straps are captured on every rising edge and the static outputs follow them one cycle later. From the first edge with `rst` low, every output is independent of `strap_pins` until the next reset.
- R2: The strap field positions are: [3:0] board identification, [4] oscillator select, [5] bit-clock direction, [7:6] external ratio code, [10:8] frequency code, [11] PLL enable, [13:12] system ratio code, [15:14] memory ratio code.
- R3: The external ratio code sets `ext_clk_en` to one pulse per 3 core cycles for 00, 4 for 01, 5 for 10 and 6 for 11.
- R4: The system ratio code sets `sys_clk_en` to one pulse per 2 core cycles for 00, 3 for 01, and 4 for 10 or 11.
- R5: The memory ratio code holds `mem_clk_en` high on every cycle for 00. For 01 it gives two pulses per 3 cycles, at phases 0 and 2 of each period. For 10 or 11 it gives one pulse per 2 cycles.
- R6: All three enables are low while reset is held. Each divider starts at phase 0 on reset release, so every enable is high in the cycle after the first edge with `rst` low.
- R7: `pll_enable` equals strap bit 11, `pll_bypass` is its complement, and `pll_freq_code` equals strap bits [10:8].
- R8: `sclk_is_output` equals strap bit 5 (1 = master, bit clock driven out), and `osc_from_pixclk` equals strap bit 4.
- R9: `board_id` equals the straps [3:0] captured during reset, and it stays readable unchanged afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high power-on reset; straps are sampled while it is high |
| strap_pins | input | 16 | Board configuration pins |
| sys_clk_en | output | 1 | System clock enable pulse |
| mem_clk_en | output | 1 | Memory clock enable pulse |
| ext_clk_en | output | 1 | External device clock enable pulse |
| pll_enable | output | 1 | PLL enabled |
| pll_bypass | output | 1 | Reference clock used directly |
| pll_freq_code | output | 3 | Core frequency selection passed to the PLL |
| sclk_is_output | output | 1 | Serial bit clock driven out (master) when high |
| osc_from_pixclk | output | 1 | Timer and baud oscillator taken from the pixel-clock input |
| board_id | output | 4 | Board identification bits held from power-on |

## Verification
If the captured configuration were corrupted or failed to freeze, the static outputs would differ from the straps driven during reset. This would show one cycle after the strap pins change. A divider counter that starts at the wrong phase or wraps at the wrong count shows up in the pulse pattern within one period, which is at most six cycles. The bench compares every enable on every cycle against a per-cycle model built from the ratio codes. It also changes the straps after release, so that a latch that keeps sampling outside the reset window produces wrong outputs.

// File: rtl/strap_clk_pkg.sv
package strap_clk_pkg;

  localparam int STRAP_W   = 16;
  localparam int DIV_CNT_W = 3;
  localparam int NUM_DIV   = 3;

  typedef struct packed {
    logic [1:0] mem_code;
    logic [1:0] sys_code;
    logic       pll_on;
    logic [2:0] freq_code;
    logic [1:0] ext_code;
    logic       sclk_master;
    logic       osc_alt;
    logic [3:0] board_id;
  } strap_cfg_t;

  typedef struct packed {
    logic [DIV_CNT_W-1:0] period_m1;
    logic                 dual;
  } div_set_t;

  function automatic div_set_t ext_setting(input logic [1:0] code);
    div_set_t s;
    s.dual      = 1'b0;
    s.period_m1 = DIV_CNT_W'(32'd2 + 32'(code));
    return s;
  endfunction

  function automatic div_set_t sys_setting(input logic [1:0] code);
    div_set_t s;
    s.dual = 1'b0;
    case (code)
      2'b00:   s.period_m1 = DIV_CNT_W'(1);
      2'b01:   s.period_m1 = DIV_CNT_W'(2);
      default: s.period_m1 = DIV_CNT_W'(3);
    endcase
    return s;
  endfunction

  function automatic div_set_t mem_setting(input logic [1:0] code);
    div_set_t s;
    case (code)
      2'b00:   begin s.period_m1 = DIV_CNT_W'(0); s.dual = 1'b0; end
      2'b01:   begin s.period_m1 = DIV_CNT_W'(2); s.dual = 1'b1; end
      default: begin s.period_m1 = DIV_CNT_W'(1); s.dual = 1'b0; end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pins_i,
  output logic [WIDTH-1:0] held_o
);

  // Transparent sampling while reset is held, frozen afterwards (R1)
  always_ff @(posedge clk) begin
    if (rst) begin
      held_o <= pins_i;
    end
  end

endmodule

// File: rtl/ratio_divider.sv
module ratio_divider #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period_m1_i,
  input  logic             dual_i,
  output logic             en_o
);

  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = (cnt_q >= period_m1_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= ZERO;
      en_o  <= 1'b0;
    end else begin
      cnt_q <= wrap ? ZERO : cnt_q + 1'b1;
      // phase 0 always pulses; dual mode adds the last phase (R5)
      en_o  <= (cnt_q == ZERO) || (dual_i && cnt_q == period_m1_i);
    end
  end

endmodule

// File: rtl/strap_clk_unit.sv
module strap_clk_unit
  import strap_clk_pkg::*;
#(
  parameter int CNT_W = DIV_CNT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [STRAP_W-1:0] strap_pins,
  output logic               sys_clk_en,
  output logic               mem_clk_en,
  output logic               ext_clk_en,
  output logic               pll_enable,
  output logic               pll_bypass,
  output logic [2:0]         pll_freq_code,
  output logic               sclk_is_output,
  output logic               osc_from_pixclk,
  output logic [3:0]         board_id
);

  localparam int CH_SYS = 0;
  localparam int CH_MEM = 1;
  localparam int CH_EXT = 2;

  logic [STRAP_W-1:0] held;
  strap_cfg_t         cfg_q;
  div_set_t           div_set [NUM_DIV];
  logic [NUM_DIV-1:0] div_en;

  strap_capture #(.WIDTH(STRAP_W)) u_capture (
    .clk    (clk),
    .rst    (rst),
    .pins_i (strap_pins),
    .held_o (held)
  );

  assign cfg_q = strap_cfg_t'(held);

  always_comb begin
    div_set[CH_SYS] = sys_setting(cfg_q.sys_code);
    div_set[CH_MEM] = mem_setting(cfg_q.mem_code);
    div_set[CH_EXT] = ext_setting(cfg_q.ext_code);
  end

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
    ratio_divider #(.CNT_W(CNT_W)) u_div (
      .clk         (clk),
      .rst         (rst),
      .period_m1_i (div_set[g].period_m1),
      .dual_i      (div_set[g].dual),
      .en_o        (div_en[g])
    );
  end

  assign sys_clk_en      = div_en[CH_SYS];
  assign mem_clk_en      = div_en[CH_MEM];
  assign ext_clk_en      = div_en[CH_EXT];

  assign pll_enable      = cfg_q.pll_on;
  assign pll_bypass      = ~cfg_q.pll_on;
  assign pll_freq_code   = cfg_q.freq_code;
  assign sclk_is_output  = cfg_q.sclk_master;
  assign osc_from_pixclk = cfg_q.osc_alt;
  assign board_id        = cfg_q.board_id;

endmodule

// File: rtl/strap_clk_checker.sv
module strap_clk_checker
  import strap_clk_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input strap_cfg_t cfg,
  input logic       sys_en,
  input logic       mem_en,
  input logic       ext_en
);

  logic       ran_q;
  logic       ext_seen_q;
  logic [3:0] ext_gap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ran_q      <= 1'b0;
      ext_seen_q <= 1'b0;
      ext_gap_q  <= 4'd0;
    end else begin
      ran_q      <= 1'b1;
      if (ext_en) ext_seen_q <= 1'b1;
      ext_gap_q  <= ext_en ? 4'd1 : ext_gap_q + 4'd1;
    end
  end

  // R1: captured configuration never moves outside reset
  p_cfg_frozen_r1: assert property (@(posedge clk) disable iff (rst)
    ran_q |-> $stable(cfg));

  // R3: spacing of external pulses matches the ratio code
  p_ext_spacing_r3: assert property (@(posedge clk) disable iff (rst)
    (ext_en && ext_seen_q) |-> (ext_gap_q == 4'd3 + {2'b00, cfg.ext_code}));

  // R4: system enable never fires on two adjacent cycles
  p_sys_gap_r4: assert property (@(posedge clk) disable iff (rst)
    sys_en |=> !sys_en);

  // R5: full-rate memory code keeps the enable high
  p_mem_full_r5: assert property (@(posedge clk) disable iff (rst)
    (ran_q && cfg.mem_code == 2'b00) |-> mem_en);

endmodule

bind strap_clk_unit strap_clk_checker u_checker (
  .clk    (clk),
  .rst    (rst),
  .cfg    (cfg_q),
  .sys_en (sys_clk_en),
  .mem_en (mem_clk_en),
  .ext_en (ext_clk_en)
);

// File: tb/strap_clk_unit_tb_top.sv
module strap_clk_unit_tb_top;

  localparam time CLK_PERIOD = 10ns;
  localparam int  RUN_CYCLES = 30;
  localparam int  NUM_VEC    = 5;

  // entry: {straps[15:0], ext period[2:0], sys period[2:0], mem mode[1:0]}
  // straps: {mem[1:0], sys[1:0], pll, freq[2:0], ext[1:0], sclk, osc, id[3:0]}
  // mem mode: 0 = every cycle, 1 = 2-of-3, 2 = every other cycle
  localparam logic [23:0] VEC [NUM_VEC] = '{
    {2'd0, 2'd0, 1'b1, 3'd3, 2'd0, 1'b1, 1'b0, 4'h5, 3'd3, 3'd2, 2'd0},
    {2'd1, 2'd1, 1'b0, 3'd7, 2'd1, 1'b0, 1'b1, 4'hA, 3'd4, 3'd3, 2'd1},
    {2'd2, 2'd2, 1'b1, 3'd0, 2'd2, 1'b1, 1'b1, 4'hF, 3'd5, 3'd4, 2'd2},
    {2'd3, 2'd3, 1'b0, 3'd5, 2'd3, 1'b0, 1'b0, 4'h0, 3'd6, 3'd4, 2'd2},
    {2'd1, 2'd0, 1'b1, 3'd2, 2'd3, 1'b1, 1'b0, 4'h9, 3'd6, 3'd2, 2'd1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] strap_pins = 16'h0000;
  logic        sys_clk_en, mem_clk_en, ext_clk_en;
  logic        pll_enable, pll_bypass, sclk_is_output, osc_from_pixclk;
  logic [2:0]  pll_freq_code;
  logic [3:0]  board_id;

  int checks   = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  strap_clk_unit dut_i (
    .clk             (clk),
    .rst             (rst),
    .strap_pins      (strap_pins),
    .sys_clk_en      (sys_clk_en),
    .mem_clk_en      (mem_clk_en),
    .ext_clk_en      (ext_clk_en),
    .pll_enable      (pll_enable),
    .pll_bypass      (pll_bypass),
    .pll_freq_code   (pll_freq_code),
    .sclk_is_output  (sclk_is_output),
    .osc_from_pixclk (osc_from_pixclk),
    .board_id        (board_id)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic pulse_at(input int c, input int n, input logic dual);
    int ph = (c - 1) % n;
    return (ph == 0) || (dual && ph == n - 1);
  endfunction

  function automatic logic mem_pulse(input int c, input int mode);
    case (mode)
      0:       return 1'b1;
      1:       return pulse_at(c, 3, 1'b1);
      default: return pulse_at(c, 2, 1'b0);
    endcase
  endfunction

  task automatic check_static(input string tag, input logic [15:0] s);
    check({tag, " R2 R7 pll_enable"},   16'(pll_enable),      16'(s[11]));
    check({tag, " R7 pll_bypass"},      16'(pll_bypass),      16'(!s[11]));
    check({tag, " R7 pll_freq_code"},   16'(pll_freq_code),   16'(s[10:8]));
    check({tag, " R8 sclk_is_output"},  16'(sclk_is_output),  16'(s[5]));
    check({tag, " R8 osc_from_pixclk"}, 16'(osc_from_pixclk), 16'(s[4]));
    check({tag, " R9 board_id"},        16'(board_id),        16'(s[3:0]));
  endtask

  // hold reset with straps s, release, then compare enables per cycle
  task automatic run_config(input logic [15:0] s, input int ext_n, input int sys_n,
                            input int mem_m, input logic disturb);
    @(negedge clk) rst = 1'b1; strap_pins = s;
    repeat (3) @(negedge clk);
    check("R6 sys idle in reset", 16'(sys_clk_en), 16'd0);
    check("R6 mem idle in reset", 16'(mem_clk_en), 16'd0);
    check("R6 ext idle in reset", 16'(ext_clk_en), 16'd0);
    check_static("R1 in reset", s);
    rst = 1'b0;
    for (int c = 1; c <= RUN_CYCLES; c++) begin
      @(negedge clk);
      if (disturb && c == 4) strap_pins = ~s;
      check("R3 R6 ext_clk_en", 16'(ext_clk_en), 16'(pulse_at(c, ext_n, 1'b0)));
      check("R4 R6 sys_clk_en", 16'(sys_clk_en), 16'(pulse_at(c, sys_n, 1'b0)));
      check("R5 R6 mem_clk_en", 16'(mem_clk_en), 16'(mem_pulse(c, mem_m)));
    end
    check_static(disturb ? "R1 after strap change" : "after release", s);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: straps followed while reset is held
    repeat (2) @(negedge clk);
    strap_pins = 16'h0C3A;
    @(negedge clk);
    check_static("R1 tracking a", 16'h0C3A);
    strap_pins = 16'h0745;
    @(negedge clk);
    check_static("R1 tracking b", 16'h0745);

    for (int v = 0; v < NUM_VEC; v++) begin
      run_config(VEC[v][23:8], int'(VEC[v][7:5]), int'(VEC[v][4:2]),
                 int'(VEC[v][1:0]), 1'b0);
    end

    // R1: strap changes after release have no effect on ratios or statics
    run_config(VEC[1][23:8], 4, 3, 1, 1'b1);
    run_config(VEC[3][23:8], 6, 4, 2, 1'b1);

    // R6: reset mid-run restarts every divider at phase 0
    run_config(VEC[2][23:8], 5, 4, 2, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule